// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. Each source has its own enable bit for each line, so a source can be routed to either line, to both or to neither. Software reaches the block through a word-addressed register port: it can read the raw level of every source and the per-line masked status, and it can change either enable mask without a read-modify-write, because setting and clearing bits use separate addresses.

Source 0 has a second driver: a software-held latch that is set and cleared through two dedicated words. The level of source 0 is the OR of its input pin and that latch, which lets software raise an interrupt on itself for test or for deferred work. There is no priority, no vector and no edge capture; a line is high whenever any enabled source is high.

Register words used below (word address, not byte address): 0 normal status, 1 raw level, 2 normal enable (read, or write-to-set), 3 normal enable clear, 4 soft set (reads back source 0 level), 5 soft clear, 8 fast status, 9 raw level, 10 fast enable (read, or write-to-set), 11 fast enable clear.

Top module: `dual_out_intc`

## Requirements
- R1: After reset both enable masks and the soft latch are zero, both request lines are low and `rdata` is zero.
- R2: A read of word 1 or word 9 returns the level vector, where bit i (i > 0) is `src_in[i]` and bit 0 is `src_in[0]` OR the soft latch.
- R3: A write to word 2 ORs `wdata` into the normal enable mask; a write to word 3 clears every mask bit whose `wdata` bit is 1; a read of word 2 returns the normal mask.
- R4: A write to word 10 ORs `wdata` into the fast enable mask; a write to word 11 clears every mask bit whose `wdata` bit is 1; a read of word 10 returns the fast mask.
- R5: A read of word 0 returns level AND normal mask; a read of word 8 returns level AND fast mask.
- R6: A write to word 4 with `wdata` bit 0 = 1 sets the soft latch, a write to word 5 with bit 0 = 1 clears it, and writes to either word with bit 0 = 0 leave it unchanged; a read of word 4 returns the source 0 level in bit 0 and zero in bits 31..1.
- R7: `irq_o` equals, one clock later, whether any bit of (level AND normal mask) is 1.
- R8: `fiq_o` equals, one clock later, whether any bit of (level AND fast mask) is 1.
- R9: Reads of words 3, 5, 11 and of every unmapped word (6, 7, 12 to 63) return zero.
- R10: Writes to words 0, 1, 8, 9 and to every unmapped word change neither mask nor the soft latch.
- R11: `rdata` takes the value of the addressed word at the clock edge where `rd_en` is high and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NSRC (32) | Level inputs, one per source |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; loads `rdata` at the edge |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | BUS_W (32) | Write data |
| rdata | output | BUS_W (32) | Registered read data |
| irq_o | output | 1 | Normal request line, registered |
| fiq_o | output | 1 | Fast request line, registered |

## Verification
The assertions assume `wr_en` and `rd_en` are never unknown and that `addr` and `wdata` are settled whenever a strobe is high at a clock edge; they also assume that `src_in` is held steady across the edge. The bench meets this by changing every input only on the falling clock edge and issuing one bus operation at a time. Source levels come from walking-one patterns and a shift-xor sequence, so the masked-status and request-line checks see sparse, dense and empty overlaps between the level vector and each mask.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word addresses that software decodes; their positions are behaviour.
  localparam int unsigned W_IRQ_STAT = 0;
  localparam int unsigned W_IRQ_RAW  = 1;
  localparam int unsigned W_IRQ_ENA  = 2;
  localparam int unsigned W_IRQ_DIS  = 3;
  localparam int unsigned W_SOFT_SET = 4;
  localparam int unsigned W_SOFT_CLR = 5;
  localparam int unsigned W_FIQ_STAT = 8;
  localparam int unsigned W_FIQ_RAW  = 9;
  localparam int unsigned W_FIQ_ENA  = 10;
  localparam int unsigned W_FIQ_DIS  = 11;

  // Number of request lines and their index in mask arrays.
  localparam int unsigned NOUT    = 2;
  localparam int unsigned OUT_IRQ = 0;
  localparam int unsigned OUT_FIQ = 1;

  // Decoded write strobes, one per state-changing word.
  typedef struct packed {
    logic irq_set;
    logic irq_clr;
    logic fiq_set;
    logic fiq_clr;
    logic soft_set;
    logic soft_clr;
  } wr_strb_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  output wr_strb_t          strb,
  output logic              wr_inert
);

  function automatic logic word_is(input logic [ADDR_W-1:0] a,
                                   input int unsigned w);
    return 32'(a) == w;
  endfunction

  always_comb begin
    strb          = '0;
    strb.irq_set  = wr_en && word_is(addr, W_IRQ_ENA);
    strb.irq_clr  = wr_en && word_is(addr, W_IRQ_DIS);
    strb.fiq_set  = wr_en && word_is(addr, W_FIQ_ENA);
    strb.fiq_clr  = wr_en && word_is(addr, W_FIQ_DIS);
    strb.soft_set = wr_en && wbit0 && word_is(addr, W_SOFT_SET);
    strb.soft_clr = wr_en && wbit0 && word_is(addr, W_SOFT_CLR);
  end

  // Write that lands on a word with no writable state.
  assign wr_inert = wr_en && !(word_is(addr, W_IRQ_ENA) || word_is(addr, W_IRQ_DIS) ||
                               word_is(addr, W_FIQ_ENA) || word_is(addr, W_FIQ_DIS) ||
                               word_is(addr, W_SOFT_SET) || word_is(addr, W_SOFT_CLR));

endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);

  // Next mask: set and clear never arrive together (distinct words).
  function automatic logic [W-1:0] next_mask(input logic [W-1:0] cur,
                                             input logic [W-1:0] b,
                                             input logic s,
                                             input logic c);
    logic [W-1:0] n;
    n = cur;
    if (s) n = n | b;
    if (c) n = n & ~b;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= next_mask(mask, bits, set_stb, clr_stb);
  end

endmodule

// File: rtl/intc_readback.sv
module intc_readback
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NSRC   = 32,
  parameter int unsigned BUS_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   lvl,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic [NSRC-1:0]   fiq_mask,
  output logic [BUS_W-1:0]  rd_val
);

  function automatic logic [BUS_W-1:0] widen(input logic [NSRC-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  always_comb begin
    case (32'(addr))
      W_IRQ_STAT: rd_val = widen(lvl & irq_mask);
      W_IRQ_RAW:  rd_val = widen(lvl);
      W_IRQ_ENA:  rd_val = widen(irq_mask);
      W_SOFT_SET: rd_val = widen({{(NSRC-1){1'b0}}, lvl[0]});
      W_FIQ_STAT: rd_val = widen(lvl & fiq_mask);
      W_FIQ_RAW:  rd_val = widen(lvl);
      W_FIQ_ENA:  rd_val = widen(fiq_mask);
      default:    rd_val = '0;
    endcase
  end

endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NOUT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           lvl,
  input  logic [NOUT-1:0][NSRC-1:0] masks,
  output logic [NOUT-1:0]           req_q
);

  function automatic logic any_hit(input logic [NSRC-1:0] l,
                                   input logic [NSRC-1:0] m);
    return |(l & m);
  endfunction

  genvar g;
  generate
    for (g = 0; g < NOUT; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q[g] <= 1'b0;
        else        req_q[g] <= any_hit(lvl, masks[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/dual_out_intc.sv
module dual_out_intc
  import intc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq_o,
  output logic              fiq_o
);

  wr_strb_t                  strb;
  logic                      wr_inert;
  logic                      soft_q;
  logic [NSRC-1:0]           lvl;
  logic [NOUT-1:0][NSRC-1:0] mask_q;
  logic [NOUT-1:0]           set_v;
  logic [NOUT-1:0]           clr_v;
  logic [NOUT-1:0]           req_q;
  logic [NSRC-1:0]           irq_mask;
  logic [NSRC-1:0]           fiq_mask;
  logic [BUS_W-1:0]          rd_val;

  intc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en    (wr_en),
    .addr     (addr),
    .wbit0    (wdata[0]),
    .strb     (strb),
    .wr_inert (wr_inert)
  );

  assign set_v[OUT_IRQ] = strb.irq_set;
  assign clr_v[OUT_IRQ] = strb.irq_clr;
  assign set_v[OUT_FIQ] = strb.fiq_set;
  assign clr_v[OUT_FIQ] = strb.fiq_clr;

  genvar g;
  generate
    for (g = 0; g < NOUT; g++) begin : g_mask
      intc_mask_reg #(.W(NSRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_v[g]),
        .clr_stb (clr_v[g]),
        .bits    (wdata[NSRC-1:0]),
        .mask    (mask_q[g])
      );
    end
  endgenerate

  assign irq_mask = mask_q[OUT_IRQ];
  assign fiq_mask = mask_q[OUT_FIQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             soft_q <= 1'b0;
    else if (strb.soft_set) soft_q <= 1'b1;
    else if (strb.soft_clr) soft_q <= 1'b0;
  end

  assign lvl = src_in | {{(NSRC-1){1'b0}}, soft_q};

  intc_readback #(.ADDR_W(ADDR_W), .NSRC(NSRC), .BUS_W(BUS_W)) u_rb (
    .addr     (addr),
    .lvl      (lvl),
    .irq_mask (irq_mask),
    .fiq_mask (fiq_mask),
    .rd_val   (rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  intc_out_stage #(.NSRC(NSRC), .NOUT(NOUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .masks (mask_q),
    .req_q (req_q)
  );

  assign irq_o = req_q[OUT_IRQ];
  assign fiq_o = req_q[OUT_FIQ];

endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              wr_inert,
  input logic              soft_q,
  input logic [NSRC-1:0]   lvl,
  input logic [NSRC-1:0]   irq_mask,
  input logic [NSRC-1:0]   fiq_mask
);

  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0];

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!irq_o && !fiq_o && rdata == '0));

  p_irq_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(lvl & irq_mask)));

  p_fiq_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|(lvl & fiq_mask)));

  p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(addr) == W_IRQ_ENA) |=> ((irq_mask & $past(wbits)) == $past(wbits)));

  p_irq_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(addr) == W_IRQ_DIS) |=> ((irq_mask & $past(wbits)) == '0));

  p_fiq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(addr) == W_FIQ_ENA) |=> ((fiq_mask & $past(wbits)) == $past(wbits)));

  p_fiq_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(addr) == W_FIQ_DIS) |=> ((fiq_mask & $past(wbits)) == '0));

  p_soft_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[0] && 32'(addr) == W_SOFT_SET) |=> soft_q);

  p_soft_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[0] && 32'(addr) == W_SOFT_CLR) |=> !soft_q);

  p_inert_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inert |=> ($stable(irq_mask) && $stable(fiq_mask) && $stable(soft_q)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind dual_out_intc intc_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .wr_inert (wr_inert),
  .soft_q   (soft_q),
  .lvl      (lvl),
  .irq_mask (irq_mask),
  .fiq_mask (fiq_mask)
);

// File: tb/dual_out_intc_tb.sv
module dual_out_intc_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  logic        fiq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] m_irq = '0;
  logic [31:0] m_fiq = '0;
  logic        m_soft = 1'b0;
  logic [31:0] rng = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_out_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] model_lvl();
    logic [31:0] v;
    v = src_in;
    v[0] = v[0] | m_soft;
    return v;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] l;
    l = model_lvl();
    case (a)
      0:       return l & m_irq;
      1, 9:    return l;
      2:       return m_irq;
      4:       return {31'd0, l[0]};
      8:       return l & m_fiq;
      10:      return m_fiq;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2:  m_irq = m_irq | d;
      3:  m_irq = m_irq & ~d;
      10: m_fiq = m_fiq | d;
      11: m_fiq = m_fiq & ~d;
      4:  if (d[0]) m_soft = 1'b1;
      5:  if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_check(input string req, input int a);
    logic [31:0] v;
    logic [31:0] e;
    e = model_read(a);
    bus_rd(a, v);
    check(req, v, e);
  endtask

  // Outputs reflect level and masks of the previous edge; masks are settled.
  task automatic line_check(input string rq_i, input string rq_f);
    @(negedge clk);
    @(negedge clk);
    check(rq_i, {31'd0, irq_o}, {31'd0, |(model_lvl() & m_irq)});
    check(rq_f, {31'd0, fiq_o}, {31'd0, |(model_lvl() & m_fiq)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 rdata", rdata, 32'd0);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
    rd_check("R1 irq mask", 2);
    rd_check("R1 fiq mask", 10);
    rd_check("R1 soft", 4);

    // R3: walk set bits into normal mask, then clear every other one
    for (int i = 0; i < 32; i++) begin
      bus_wr(2, 32'h1 << i);
      rd_check("R3 set walk", 2);
    end
    bus_wr(3, 32'h5555_5555);
    rd_check("R3 clear pattern", 2);
    bus_wr(3, 32'hFFFF_FFFF);
    rd_check("R3 clear all", 2);

    // R4: same for fast mask
    for (int i = 0; i < 32; i++) begin
      bus_wr(10, 32'h8000_0000 >> i);
      rd_check("R4 set walk", 10);
    end
    bus_wr(11, 32'hF0F0_0F0F);
    rd_check("R4 clear pattern", 10);

    // R2/R5/R7/R8: walking-one source with split masks
    bus_wr(11, 32'hFFFF_FFFF);
    bus_wr(2, 32'h0000_FFFF);
    bus_wr(10, 32'hFF00_FF00);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      src_in = 32'h1 << i;
      rd_check("R2 raw", 1);
      rd_check("R5 irq status", 0);
      rd_check("R5 fiq status", 8);
      line_check("R7 walk", "R8 walk");
    end

    // Random levels and mask edits
    for (int k = 0; k < 60; k++) begin
      next_rand();
      @(negedge clk);
      src_in = rng & (k[0] ? 32'hFFFF_FFFF : 32'h0101_0101);
      next_rand();
      case (k % 4)
        0: bus_wr(2, rng);
        1: bus_wr(3, rng);
        2: bus_wr(10, rng);
        default: bus_wr(11, rng);
      endcase
      rd_check("R2 raw alt", 9);
      rd_check("R5 irq status rnd", 0);
      rd_check("R5 fiq status rnd", 8);
      line_check("R7 rnd", "R8 rnd");
    end

    // R6: soft latch drives source 0
    @(negedge clk);
    src_in = 32'h0;
    bus_wr(2, 32'h1);
    bus_wr(11, 32'h1);
    bus_wr(4, 32'hFFFF_FFFE);
    rd_check("R6 set without bit0", 4);
    bus_wr(4, 32'h1);
    rd_check("R6 soft set", 4);
    rd_check("R6 raw bit0", 1);
    line_check("R7 soft", "R8 soft");
    bus_wr(5, 32'hFFFF_FFFE);
    rd_check("R6 clear without bit0", 4);
    bus_wr(5, 32'h1);
    rd_check("R6 soft clear", 4);
    line_check("R7 soft off", "R8 soft off");
    @(negedge clk);
    src_in = 32'hFFFF_FFFF;
    rd_check("R6 read 4 pin only", 4);

    // R9 and full read sweep
    bus_wr(4, 32'h1);
    for (int a = 0; a < 64; a++) begin
      rd_check((a == 3 || a == 5 || a == 11 || a == 6 || a == 7 || a > 11)
               ? "R9 zero word" : "R5 sweep", a);
    end

    // R10: inert writes leave state alone
    for (int a = 0; a < 64; a++) begin
      if (!(a == 2 || a == 3 || a == 4 || a == 5 || a == 10 || a == 11)) begin
        bus_wr(a, (a % 2) ? 32'hFFFF_FFFF : 32'h0);
        bus_wr(a, 32'hFFFF_FFFF);
      end
    end
    rd_check("R10 irq mask kept", 2);
    rd_check("R10 fiq mask kept", 10);
    @(negedge clk);
    src_in = 32'h0;
    rd_check("R10 soft kept", 4);

    // R11: rdata holds while idle and state changes
    bus_rd(2, held);
    bus_wr(2, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check("R11 rdata held", rdata, held);
    rd_check("R11 new value", 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule